// File: doc/BRIEF.md
# Transmit Buffer Early Release Controller

This block tracks free space in a 3 KB transmit buffer shared by several queued frames. Each frame occupies a slot in a small table. When a frame is allocated, its charge comes off the free count: its length, capped at the buffer size. Writers report when a frame has been fully stored and when its processing, such as checksum insertion, has finished. The transmit side reports which slot heads the queue, which slot is being sent, how many bytes of that frame have reached the MAC synchronisation FIFO, collisions, and completion.

With the early-release enable clear, a frame's charge returns to the free count only when its transmission completes. With the enable set, the charge returns as soon as every safety condition holds together. The frame must be at the head of the queue, fully written, fully processed, and no larger than the buffer. More than 128 of its bytes must have left for the synchronisation FIFO, so the collision window has passed. A frame is released only once. A frame released early frees nothing again at completion.

The release strobe and its slot, byte count and kind are combinational from the current table state and inputs. The free count is registered and updates on the next clock edge.

Top module: `tx_early_release`

## Requirements
- R1: After reset `free_bytes` equals 3072 and `rel_vld` is 0.
- R2: An allocation lowers `free_bytes` on the next edge by the frame length, capped at 3072 for frames longer than the buffer.
- R3: With `cfg_early_en` = 0, no release occurs while a frame is sending. A `tx_done_vld` on an unreleased slot gives `rel_vld` = 1, `rel_early` = 0 and `rel_bytes` equal to the charge. The free count rises by that amount on the next edge.
- R4: With early release enabled, `rel_vld` = 1 and `rel_early` = 1 are asserted in the first cycle in which all conditions hold. `rel_slot` equals `tx_slot` and `rel_bytes` equals the frame length.
- R5: Early release requires `sync_bytes` strictly greater than 128: a value of 128 gives no release and 129 does.
- R6: Early release requires both the written and the processed indications for the slot. Either one alone gives no release.
- R7: Early release requires `tx_slot` equal to `head_slot`. A ready frame being sent while another slot is at the head is not released.
- R8: A frame longer than 3072 bytes is never released early. At completion it frees 3072.
- R9: A slot is released at most once per allocation. After an early release, further cycles and its `tx_done_vld` produce no strobe and leave `free_bytes` unchanged.
- R10: A cycle with `tx_collision` = 1 produces no early release. The frame stays charged and is released in a later clean cycle.
- R11: An allocation and a release in the same cycle both take effect: the new free count is the old count minus the charge plus the released bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_early_en | input | 1 | Early-release enable from configuration |
| alloc_vld | input | 1 | Allocate a slot for a new frame |
| alloc_slot | input | 2 | Slot being allocated |
| alloc_len | input | 13 | Length of the new frame in bytes |
| wr_done_vld | input | 1 | Frame fully written into the buffer |
| wr_done_slot | input | 2 | Slot that finished writing |
| proc_done_vld | input | 1 | Frame processing finished |
| proc_done_slot | input | 2 | Slot whose processing finished |
| head_slot | input | 2 | Oldest frame in the queue |
| tx_active | input | 1 | A frame is being sent |
| tx_slot | input | 2 | Slot being sent |
| sync_bytes | input | 13 | Bytes of the sending frame passed to the sync FIFO |
| tx_collision | input | 1 | Collision seen this cycle |
| tx_done_vld | input | 1 | Frame transmission completed |
| tx_done_slot | input | 2 | Slot that completed |
| rel_vld | output | 1 | Space release strobe |
| rel_early | output | 1 | Release is early (1) or at completion (0) |
| rel_slot | output | 2 | Slot being released |
| rel_bytes | output | 12 | Bytes returned to the free count |
| free_bytes | output | 12 | Current free space in bytes |

## Verification
The hardest case to reach is a frame that is fully ready but not at the head of the queue, because that only happens under preemptive ordering. The bench sets up two ready slots, points the head at one and sends the other. It then moves the head and confirms that release follows. The sequence of a threshold value that just fails and then just passes confirms that release comes in the first cycle. The bench also sends a completion after an early release to confirm that no second free happens. It drives an allocation in the same cycle as a release to check the combined update.

// File: rtl/tx_er_pkg.sv
package tx_er_pkg;

  // Bytes a frame occupies in the buffer: its length, capped at capacity.
  function automatic logic [15:0] charge_of(input logic [15:0] len,
                                            input logic [15:0] cap);
    return (len > cap) ? cap : len;
  endfunction

  // True once strictly more than the threshold has left for the sync FIFO.
  function automatic logic past_window(input logic [15:0] sent,
                                       input logic [15:0] thresh);
    return sent > thresh;
  endfunction

  // A frame larger than the buffer never qualifies for early release.
  function automatic logic oversized(input logic [15:0] len,
                                     input logic [15:0] cap);
    return len > cap;
  endfunction

endpackage

// File: rtl/tx_er_slot_table.sv
module tx_er_slot_table #(
  parameter int SLOTS = 4,
  parameter int LEN_W = 13,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_vld,
  input  logic [SLOT_W-1:0]             alloc_slot,
  input  logic [LEN_W-1:0]              alloc_len,
  input  logic                          wr_done_vld,
  input  logic [SLOT_W-1:0]             wr_done_slot,
  input  logic                          proc_done_vld,
  input  logic [SLOT_W-1:0]             proc_done_slot,
  input  logic                          mark_vld,
  input  logic [SLOT_W-1:0]             mark_slot,
  input  logic                          retire_vld,
  input  logic [SLOT_W-1:0]             retire_slot,
  output logic [SLOTS-1:0]              valid_o,
  output logic [SLOTS-1:0]              written_o,
  output logic [SLOTS-1:0]              processed_o,
  output logic [SLOTS-1:0]              released_o,
  output logic [SLOTS-1:0][LEN_W-1:0]   len_o
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [SLOT_W-1:0] ID = SLOT_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g]     <= 1'b0;
        written_o[g]   <= 1'b0;
        processed_o[g] <= 1'b0;
        released_o[g]  <= 1'b0;
        len_o[g]       <= '0;
      end else if (alloc_vld && alloc_slot == ID) begin
        valid_o[g]     <= 1'b1;
        written_o[g]   <= 1'b0;
        processed_o[g] <= 1'b0;
        released_o[g]  <= 1'b0;
        len_o[g]       <= alloc_len;
      end else if (retire_vld && retire_slot == ID) begin
        valid_o[g]     <= 1'b0;
        written_o[g]   <= 1'b0;
        processed_o[g] <= 1'b0;
        released_o[g]  <= 1'b0;
      end else begin
        if (wr_done_vld && wr_done_slot == ID)     written_o[g]   <= 1'b1;
        if (proc_done_vld && proc_done_slot == ID) processed_o[g] <= 1'b1;
        if (mark_vld && mark_slot == ID)           released_o[g]  <= 1'b1;
      end
    end
  end

  // R9
  mark_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld |-> (valid_o[mark_slot] && !released_o[mark_slot]));

  // R9
  mark_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_vld && !alloc_vld && !retire_vld) |=> released_o[$past(mark_slot)]);

endmodule

// File: rtl/tx_er_qualify.sv
module tx_er_qualify #(
  parameter int SLOTS     = 4,
  parameter int LEN_W     = 13,
  parameter int SYNC_W    = 13,
  parameter int BUF_BYTES = 3072,
  parameter int THRESH    = 128,
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              en,
  input  logic              tx_active,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [SLOT_W-1:0] head_slot,
  input  logic              sel_valid,
  input  logic              sel_written,
  input  logic              sel_processed,
  input  logic              sel_released,
  input  logic [LEN_W-1:0]  sel_len,
  input  logic [SYNC_W-1:0] sync_bytes,
  input  logic              collision,
  input  logic              done_vld,
  output logic              early_ok
);
  import tx_er_pkg::*;

  logic c_head, c_ready, c_fits, c_window, c_clean;

  always_comb begin
    c_head   = tx_active && (tx_slot == head_slot);
    c_ready  = sel_valid && sel_written && sel_processed && !sel_released;
    c_fits   = !oversized(16'(sel_len), 16'(BUF_BYTES));
    c_window = past_window(16'(sync_bytes), 16'(THRESH));
    c_clean  = !collision && !done_vld;
    early_ok = en && c_head && c_ready && c_fits && c_window && c_clean;
  end

endmodule

// File: rtl/tx_er_space_ctr.sv
module tx_er_space_ctr #(
  parameter int BUF_BYTES = 3072,
  parameter int LEN_W     = 13,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_vld,
  input  logic [LEN_W-1:0] alloc_len,
  input  logic             rel_vld,
  input  logic [CNT_W-1:0] rel_bytes,
  output logic [CNT_W-1:0] free_bytes
);
  import tx_er_pkg::*;

  logic [CNT_W-1:0] take;
  logic [CNT_W-1:0] give;
  logic [CNT_W:0]   nxt;

  always_comb begin
    take = alloc_vld ? CNT_W'(charge_of(16'(alloc_len), 16'(BUF_BYTES))) : '0;
    give = rel_vld ? rel_bytes : '0;
    nxt  = {1'b0, free_bytes} + {1'b0, give} - {1'b0, take};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_bytes <= CNT_W'(BUF_BYTES);
    else        free_bytes <= nxt[CNT_W-1:0];
  end

  // R2
  free_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_bytes <= CNT_W'(BUF_BYTES));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_vld && !rel_vld) |=> $stable(free_bytes));

endmodule

// File: rtl/tx_early_release.sv
module tx_early_release #(
  parameter int SLOTS     = 4,
  parameter int LEN_W     = 13,
  parameter int SYNC_W    = 13,
  parameter int BUF_BYTES = 3072,
  parameter int THRESH    = 128,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_early_en,
  input  logic              alloc_vld,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic              wr_done_vld,
  input  logic [SLOT_W-1:0] wr_done_slot,
  input  logic              proc_done_vld,
  input  logic [SLOT_W-1:0] proc_done_slot,
  input  logic [SLOT_W-1:0] head_slot,
  input  logic              tx_active,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [SYNC_W-1:0] sync_bytes,
  input  logic              tx_collision,
  input  logic              tx_done_vld,
  input  logic [SLOT_W-1:0] tx_done_slot,
  output logic              rel_vld,
  output logic              rel_early,
  output logic [SLOT_W-1:0] rel_slot,
  output logic [CNT_W-1:0]  rel_bytes,
  output logic [CNT_W-1:0]  free_bytes
);
  import tx_er_pkg::*;

  logic [SLOTS-1:0]            valid, written, processed, released;
  logic [SLOTS-1:0][LEN_W-1:0] len;
  logic                        early_ok;
  logic                        done_hit;
  logic [LEN_W-1:0]            rel_len;

  assign done_hit  = tx_done_vld && valid[tx_done_slot] && !released[tx_done_slot];
  assign rel_vld   = done_hit || early_ok;
  assign rel_early = early_ok;
  assign rel_slot  = done_hit ? tx_done_slot : tx_slot;
  assign rel_len   = len[rel_slot];
  assign rel_bytes = CNT_W'(charge_of(16'(rel_len), 16'(BUF_BYTES)));

  tx_er_slot_table #(.SLOTS(SLOTS), .LEN_W(LEN_W)) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_vld      (alloc_vld),
    .alloc_slot     (alloc_slot),
    .alloc_len      (alloc_len),
    .wr_done_vld    (wr_done_vld),
    .wr_done_slot   (wr_done_slot),
    .proc_done_vld  (proc_done_vld),
    .proc_done_slot (proc_done_slot),
    .mark_vld       (early_ok),
    .mark_slot      (tx_slot),
    .retire_vld     (tx_done_vld),
    .retire_slot    (tx_done_slot),
    .valid_o        (valid),
    .written_o      (written),
    .processed_o    (processed),
    .released_o     (released),
    .len_o          (len)
  );

  tx_er_qualify #(
    .SLOTS(SLOTS), .LEN_W(LEN_W), .SYNC_W(SYNC_W),
    .BUF_BYTES(BUF_BYTES), .THRESH(THRESH)
  ) u_qual (
    .en            (cfg_early_en),
    .tx_active     (tx_active),
    .tx_slot       (tx_slot),
    .head_slot     (head_slot),
    .sel_valid     (valid[tx_slot]),
    .sel_written   (written[tx_slot]),
    .sel_processed (processed[tx_slot]),
    .sel_released  (released[tx_slot]),
    .sel_len       (len[tx_slot]),
    .sync_bytes    (sync_bytes),
    .collision     (tx_collision),
    .done_vld      (tx_done_vld),
    .early_ok      (early_ok)
  );

  tx_er_space_ctr #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_space (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_vld  (alloc_vld),
    .alloc_len  (alloc_len),
    .rel_vld    (rel_vld),
    .rel_bytes  (rel_bytes),
    .free_bytes (free_bytes)
  );

  // R3
  early_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> cfg_early_en);

  // R5
  early_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> (sync_bytes > SYNC_W'(THRESH)));

  // R7
  early_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> (tx_slot == head_slot && rel_slot == tx_slot));

  // R6
  early_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> (written[rel_slot] && processed[rel_slot]));

  // R8
  early_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> (rel_len <= LEN_W'(BUF_BYTES)));

  // R10
  early_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_early |-> !tx_collision);

endmodule

// File: tb/tx_early_release_bench.sv
module tx_early_release_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_early_en = 1'b0;
  logic        alloc_vld = 1'b0;
  logic [1:0]  alloc_slot = '0;
  logic [12:0] alloc_len = '0;
  logic        wr_done_vld = 1'b0;
  logic [1:0]  wr_done_slot = '0;
  logic        proc_done_vld = 1'b0;
  logic [1:0]  proc_done_slot = '0;
  logic [1:0]  head_slot = '0;
  logic        tx_active = 1'b0;
  logic [1:0]  tx_slot = '0;
  logic [12:0] sync_bytes = '0;
  logic        tx_collision = 1'b0;
  logic        tx_done_vld = 1'b0;
  logic [1:0]  tx_done_slot = '0;
  logic        rel_vld, rel_early;
  logic [1:0]  rel_slot;
  logic [11:0] rel_bytes, free_bytes;

  int tests = 0;
  int fails = 0;
  int exp_free = 3072;

  always #4 clk = ~clk;

  tx_early_release u_tx_early_release (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one clock and return to the falling edge with pulses cleared.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    alloc_vld = 0; wr_done_vld = 0; proc_done_vld = 0; tx_done_vld = 0;
  endtask

  function automatic int cap(input int l);
    return (l > 3072) ? 3072 : l;
  endfunction

  task automatic alloc(input int s, input int l);
    alloc_vld = 1; alloc_slot = 2'(s); alloc_len = 13'(l);
    step();
    exp_free -= cap(l);
    chk("R2", free_bytes, exp_free);
  endtask

  task automatic ready(input int s);
    wr_done_vld = 1; wr_done_slot = 2'(s);
    proc_done_vld = 1; proc_done_slot = 2'(s);
    step();
  endtask

  task automatic send(input int s, input int h, input int n);
    tx_active = 1; tx_slot = 2'(s); head_slot = 2'(h); sync_bytes = 13'(n);
  endtask

  task automatic probe(input string req, input bit v, input bit e,
                       input int s, input int b);
    #1;
    chk(req, rel_vld, v);
    if (v) begin
      chk(req, rel_early, e);
      chk(req, rel_slot, s);
      chk(req, rel_bytes, b);
    end
  endtask

  task automatic finish_tx(input int s, input string req, input bit v, input int b);
    tx_done_vld = 1; tx_done_slot = 2'(s);
    probe(req, v, 1'b0, s, b);
    step();
    tx_active = 0;
    if (v) exp_free += b;
    chk(req, free_bytes, exp_free);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", free_bytes, 3072);
    chk("R1", rel_vld, 0);
  endtask

  task automatic t_disabled();
    cfg_early_en = 0;
    alloc(0, 1000);
    ready(0);
    send(0, 0, 500);
    probe("R3", 0, 0, 0, 0);
    step();
    finish_tx(0, "R3", 1, 1000);
    cfg_early_en = 1;
  endtask

  task automatic t_threshold_once();
    alloc(1, 600);
    ready(1);
    send(1, 1, 128);
    probe("R5", 0, 0, 0, 0);
    step();
    sync_bytes = 129;
    probe("R4", 1, 1, 1, 600);
    step();
    exp_free += 600;
    chk("R4", free_bytes, exp_free);
    sync_bytes = 200;
    probe("R9", 0, 0, 0, 0);
    step();
    chk("R9", free_bytes, exp_free);
    finish_tx(1, "R9", 0, 0);
  endtask

  task automatic t_ready_flags();
    alloc(2, 300);
    wr_done_vld = 1; wr_done_slot = 2;
    step();
    send(2, 2, 300);
    probe("R6", 0, 0, 0, 0);
    proc_done_vld = 1; proc_done_slot = 2;
    step();
    probe("R6", 1, 1, 2, 300);
    step();
    exp_free += 300;
    finish_tx(2, "R6", 0, 0);
    alloc(3, 200);
    proc_done_vld = 1; proc_done_slot = 3;
    step();
    send(3, 3, 300);
    probe("R6", 0, 0, 0, 0);
    wr_done_vld = 1; wr_done_slot = 3;
    step();
    probe("R6", 1, 1, 3, 200);
    step();
    exp_free += 200;
    finish_tx(3, "R6", 0, 0);
  endtask

  task automatic t_not_head();
    alloc(0, 400);
    alloc(1, 500);
    ready(0);
    ready(1);
    send(1, 0, 300);
    probe("R7", 0, 0, 0, 0);
    step();
    chk("R7", free_bytes, exp_free);
    head_slot = 1;
    probe("R7", 1, 1, 1, 500);
    step();
    exp_free += 500;
    finish_tx(1, "R7", 0, 0);
    send(0, 0, 300);
    probe("R7", 1, 1, 0, 400);
    step();
    exp_free += 400;
    finish_tx(0, "R7", 0, 0);
  endtask

  task automatic t_oversized();
    alloc(2, 4000);
    chk("R8", free_bytes, 0);
    ready(2);
    send(2, 2, 1000);
    probe("R8", 0, 0, 0, 0);
    step();
    finish_tx(2, "R8", 1, 3072);
  endtask

  task automatic t_collision();
    alloc(3, 700);
    ready(3);
    send(3, 3, 200);
    tx_collision = 1;
    probe("R10", 0, 0, 0, 0);
    step();
    chk("R10", free_bytes, exp_free);
    tx_collision = 0;
    probe("R10", 1, 1, 3, 700);
    step();
    exp_free += 700;
    finish_tx(3, "R10", 0, 0);
  endtask

  task automatic t_same_cycle();
    alloc(0, 800);
    ready(0);
    send(0, 0, 200);
    alloc_vld = 1; alloc_slot = 1; alloc_len = 1000;
    probe("R11", 1, 1, 0, 800);
    step();
    exp_free = exp_free - 1000 + 800;
    chk("R11", free_bytes, exp_free);
    finish_tx(0, "R11", 0, 0);
    finish_tx(1, "R11", 1, 1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_threshold_once();
    t_ready_flags();
    t_not_head();
    t_oversized();
    t_collision();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule